// File: doc/BRIEF.md
# Age-Ordered Compacting Issue Queue

This block is a single-issue instruction window. Waiting instructions sit in physical slots whose index is their age: slot 0 holds the oldest entry, and the occupied slots always form a gap-free run that starts at slot 0. Each entry carries a payload and two source operand tags, and each tag has a ready flag. A result-tag broadcast sets the ready flag of every stored source whose tag matches. The broadcast also applies to the sources of an instruction being dispatched in that cycle.

Because the slots are in age order, selection is a priority encoder that gives precedence to the lowest slot. The chosen entry leaves the queue in the cycle it is presented. In that same cycle the slots above it each move down by one to close the gap. A new instruction is written just above the surviving entries. A flush empties the whole window in one cycle.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `issue_valid_o` is 0 and `disp_ready_o` is 1.
- R2: An entry is presented on the issue port only when both of its source ready flags are set.
- R3: When several entries are issuable, the one presented is the oldest, meaning the one dispatched earliest.
- R4: After an entry issues, the remaining entries keep their relative age order.
- R5: A dispatch accepted in the same cycle as an issue becomes the youngest entry, behind every survivor.
- R6: A broadcast with `wb_valid_i` = 1 sets every stored source whose tag equals `wb_tag_i`. The entry can issue from the next cycle on.
- R7: A broadcast in the dispatch cycle also sets the matching sources of the instruction being dispatched.
- R8: `disp_ready_o` is 0 when all DEPTH slots are occupied and nothing issues in that cycle. It is 1 when a slot is free, or when the queue is full and an entry issues in that cycle.
- R9: `flush_i` = 1 empties the queue at the next edge. In the flush cycle nothing issues and no dispatch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all entries |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | Dispatch can be accepted this cycle |
| disp_tag0_i | input | TAG_W | First source tag |
| disp_rdy0_i | input | 1 | First source already available |
| disp_tag1_i | input | TAG_W | Second source tag |
| disp_rdy1_i | input | 1 | Second source already available |
| disp_payload_i | input | PL_W | Instruction payload |
| wb_valid_i | input | 1 | Result tag broadcast valid |
| wb_tag_i | input | TAG_W | Broadcast result tag |
| issue_valid_o | output | 1 | An entry issues this cycle |
| issue_payload_o | output | PL_W | Payload of the issuing entry |

## Verification
Three functions can fall in the same cycle: issue with compaction, dispatch into the top free slot, and a broadcast that wakes both stored and incoming sources. The bench provokes these collisions in directed sequences. One sequence dispatches while an older entry issues. Another dispatches with a matching broadcast. A third offers a dispatch to a full queue that issues in that cycle. A long pseudo-random sweep on a four-slot queue then mixes all of them with occasional flushes. An in-order reference list in the bench predicts the outcome, and every cycle compares the issued payload and the dispatch readiness against it.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEPTH = 8;
  localparam int unsigned IQ_TAG_W = 6;
  localparam int unsigned IQ_PL_W  = 16;

  function automatic int unsigned iq_idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
  parameter int unsigned TAG_W = 6
) (
  input  logic             rdy_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             bc_valid_i,
  input  logic [TAG_W-1:0] bc_tag_i,
  output logic             rdy_o
);
  assign rdy_o = rdy_i | (bc_valid_i & (bc_tag_i == tag_i));
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [DEPTH-1:0] req_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  // lowest slot (oldest) wins
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = IQ_DEPTH,
  parameter int unsigned TAG_W = IQ_TAG_W,
  parameter int unsigned PL_W  = IQ_PL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             disp_valid_i,
  output logic             disp_ready_o,
  input  logic [TAG_W-1:0] disp_tag0_i,
  input  logic             disp_rdy0_i,
  input  logic [TAG_W-1:0] disp_tag1_i,
  input  logic             disp_rdy1_i,
  input  logic [PL_W-1:0]  disp_payload_i,
  input  logic             wb_valid_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  output logic             issue_valid_o,
  output logic [PL_W-1:0]  issue_payload_o
);
  localparam int unsigned IDX_W = iq_idx_w(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] valid_q, rdy0_q, rdy1_q;
  logic [TAG_W-1:0] tag0_q [DEPTH];
  logic [TAG_W-1:0] tag1_q [DEPTH];
  logic [PL_W-1:0]  pl_q   [DEPTH];

  logic [DEPTH-1:0] valid_d, rdy0_d, rdy1_d;
  logic [TAG_W-1:0] tag0_d [DEPTH];
  logic [TAG_W-1:0] tag1_d [DEPTH];
  logic [PL_W-1:0]  pl_d   [DEPTH];

  logic [DEPTH-1:0] rdy0_w, rdy1_w;
  logic [DEPTH-1:0] up_valid, up_rdy0, up_rdy1;
  logic [TAG_W-1:0] up_tag0 [DEPTH];
  logic [TAG_W-1:0] up_tag1 [DEPTH];
  logic [PL_W-1:0]  up_pl   [DEPTH];

  logic             disp_rdy0_w, disp_rdy1_w;
  logic             sel_valid;
  logic [IDX_W-1:0] sel_idx;
  logic             issue_fire, disp_fire;
  logic [CNT_W-1:0] occ, wr_idx;

  // wakeup per stored source
  for (genvar i = 0; i < DEPTH; i++) begin : g_wake
    iq_wakeup #(.TAG_W(TAG_W)) wk0_i (
      .rdy_i(rdy0_q[i]), .tag_i(tag0_q[i]),
      .bc_valid_i(wb_valid_i), .bc_tag_i(wb_tag_i), .rdy_o(rdy0_w[i]));
    iq_wakeup #(.TAG_W(TAG_W)) wk1_i (
      .rdy_i(rdy1_q[i]), .tag_i(tag1_q[i]),
      .bc_valid_i(wb_valid_i), .bc_tag_i(wb_tag_i), .rdy_o(rdy1_w[i]));
  end

  // wakeup of the incoming instruction
  iq_wakeup #(.TAG_W(TAG_W)) dwk0_i (
    .rdy_i(disp_rdy0_i), .tag_i(disp_tag0_i),
    .bc_valid_i(wb_valid_i), .bc_tag_i(wb_tag_i), .rdy_o(disp_rdy0_w));
  iq_wakeup #(.TAG_W(TAG_W)) dwk1_i (
    .rdy_i(disp_rdy1_i), .tag_i(disp_tag1_i),
    .bc_valid_i(wb_valid_i), .bc_tag_i(wb_tag_i), .rdy_o(disp_rdy1_w));

  // neighbour above each slot, used when compacting
  for (genvar i = 0; i < DEPTH; i++) begin : g_up
    if (i < DEPTH - 1) begin : g_mid
      assign up_valid[i] = valid_q[i+1];
      assign up_rdy0[i]  = rdy0_w[i+1];
      assign up_rdy1[i]  = rdy1_w[i+1];
      assign up_tag0[i]  = tag0_q[i+1];
      assign up_tag1[i]  = tag1_q[i+1];
      assign up_pl[i]    = pl_q[i+1];
    end else begin : g_top
      assign up_valid[i] = 1'b0;
      assign up_rdy0[i]  = 1'b0;
      assign up_rdy1[i]  = 1'b0;
      assign up_tag0[i]  = '0;
      assign up_tag1[i]  = '0;
      assign up_pl[i]    = '0;
    end
  end

  iq_select #(.DEPTH(DEPTH), .IDX_W(IDX_W)) sel_i (
    .req_i      (valid_q & rdy0_q & rdy1_q),
    .gnt_valid_o(sel_valid),
    .gnt_idx_o  (sel_idx)
  );

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + CNT_W'(valid_q[i]);
  end

  assign issue_fire      = sel_valid & ~flush_i;
  assign issue_valid_o   = issue_fire;
  assign issue_payload_o = pl_q[sel_idx];
  assign disp_ready_o    = ~valid_q[DEPTH-1] | issue_fire;
  assign disp_fire       = disp_valid_i & disp_ready_o & ~flush_i;
  assign wr_idx          = occ - CNT_W'(issue_fire);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (issue_fire && (i >= int'(sel_idx))) begin
        valid_d[i] = up_valid[i];
        rdy0_d[i]  = up_rdy0[i];
        rdy1_d[i]  = up_rdy1[i];
        tag0_d[i]  = up_tag0[i];
        tag1_d[i]  = up_tag1[i];
        pl_d[i]    = up_pl[i];
      end else begin
        valid_d[i] = valid_q[i];
        rdy0_d[i]  = rdy0_w[i];
        rdy1_d[i]  = rdy1_w[i];
        tag0_d[i]  = tag0_q[i];
        tag1_d[i]  = tag1_q[i];
        pl_d[i]    = pl_q[i];
      end
      if (disp_fire && (wr_idx == CNT_W'(i))) begin
        valid_d[i] = 1'b1;
        rdy0_d[i]  = disp_rdy0_w;
        rdy1_d[i]  = disp_rdy1_w;
        tag0_d[i]  = disp_tag0_i;
        tag1_d[i]  = disp_tag1_i;
        pl_d[i]    = disp_payload_i;
      end
      if (flush_i) valid_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rdy0_q  <= '0;
      rdy1_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag0_q[i] <= '0;
        tag1_q[i] <= '0;
        pl_q[i]   <= '0;
      end
    end else begin
      valid_q <= valid_d;
      rdy0_q  <= rdy0_d;
      rdy1_q  <= rdy1_d;
      for (int i = 0; i < DEPTH; i++) begin
        tag0_q[i] <= tag0_d[i];
        tag1_q[i] <= tag1_d[i];
        pl_q[i]   <= pl_d[i];
      end
    end
  end
endmodule

// File: rtl/iq_chk.sv
module iq_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             disp_valid_i,
  input logic             disp_ready_o,
  input logic             issue_valid_o,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] rdy0_q,
  input logic [DEPTH-1:0] rdy1_q,
  input logic [IDX_W-1:0] sel_idx
);
  logic [DEPTH-1:0] cand, below;
  assign cand  = valid_q & rdy0_q & rdy1_q;
  assign below = (DEPTH'(1) << sel_idx) - DEPTH'(1);

  assert_issue_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (valid_q[sel_idx] && rdy0_q[sel_idx] && rdy1_q[sel_idx]));

  assert_oldest_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ((cand & below) == '0));

  assert_no_holes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q & (valid_q + DEPTH'(1))) == '0);

  assert_dispatch_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_ready_o && !flush_i) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1 - int'($past(issue_valid_o))));

  assert_full_refuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q[DEPTH-1] && !issue_valid_o) |-> !disp_ready_o);

  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  assert_flush_no_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !issue_valid_o);
endmodule

bind issue_queue iq_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .issue_valid_o(issue_valid_o),
  .valid_q      (valid_q),
  .rdy0_q       (rdy0_q),
  .rdy1_q       (rdy1_q),
  .sel_idx      (sel_idx)
);

// File: tb/issue_queue_tb_top.sv
module issue_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int TAG_W = 4;
  localparam int PL_W  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush, dv, r0, r1, wv;
  logic [TAG_W-1:0] t0, t1, wt;
  logic [PL_W-1:0] pl;
  logic drdy, iv;
  logic [PL_W-1:0] ipl;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PL_W(PL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .disp_valid_i(dv), .disp_ready_o(drdy),
    .disp_tag0_i(t0), .disp_rdy0_i(r0), .disp_tag1_i(t1), .disp_rdy1_i(r1),
    .disp_payload_i(pl), .wb_valid_i(wv), .wb_tag_i(wt),
    .issue_valid_o(iv), .issue_payload_o(ipl));

  typedef struct packed {
    logic [PL_W-1:0]  p;
    logic [TAG_W-1:0] a;
    logic             ra;
    logic [TAG_W-1:0] b;
    logic             rb;
  } ment_t;

  ment_t mq[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, model update after posedge
  task automatic step(bit d, int p, int a, bit ra, int b, bit rb,
                      bit w, int wtag, bit f);
    int k;
    bit eiv, erdy, acc;
    ment_t e;
    dv = d; pl = PL_W'(p); t0 = TAG_W'(a); r0 = ra; t1 = TAG_W'(b); r1 = rb;
    wv = w; wt = TAG_W'(wtag); flush = f;
    #1;
    k = -1;
    for (int j = 0; j < mq.size(); j++)
      if (k < 0 && mq[j].ra && mq[j].rb) k = j;
    eiv  = !f && (k >= 0);
    erdy = (mq.size() < DEPTH) || eiv;
    chk(iv == eiv, f ? "R9" : "R2", int'(iv), int'(eiv));
    if (eiv && iv) chk(ipl == mq[k].p, "R3", int'(ipl), int'(mq[k].p));
    chk(drdy == erdy, "R8", int'(drdy), int'(erdy));
    acc = d && erdy && !f;
    @(posedge clk);
    if (f) mq.delete();
    else begin
      if (eiv) mq.delete(k);
      for (int j = 0; j < mq.size(); j++) begin
        e = mq[j];
        if (w && e.a == TAG_W'(wtag)) e.ra = 1'b1;
        if (w && e.b == TAG_W'(wtag)) e.rb = 1'b1;
        mq[j] = e;
      end
      if (acc) begin
        e.p = PL_W'(p); e.a = TAG_W'(a); e.b = TAG_W'(b);
        e.ra = ra | (w && TAG_W'(a) == TAG_W'(wtag));
        e.rb = rb | (w && TAG_W'(b) == TAG_W'(wtag));
        mq.push_back(e);
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic idle();
    dv = 0; pl = '0; t0 = '0; r0 = 0; t1 = '0; r1 = 0; wv = 0; wt = '0; flush = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rs;
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk(iv == 1'b0, "R1", int'(iv), 0);
    chk(drdy == 1'b1, "R1", int'(drdy), 1);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2/R3/R6
    step(1, 1, 1, 1, 2, 0, 0, 0, 0);
    #1 chk(iv == 1'b0, "R2", int'(iv), 0);
    step(1, 2, 3, 1, 4, 1, 0, 0, 0);
    #1 chk(iv && ipl == 8'd2, "R3", int'(ipl), 2);
    step(0, 0, 0, 0, 0, 0, 1, 2, 0);
    #1 chk(iv && ipl == 8'd1, "R6", int'(ipl), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    #1 chk(iv == 1'b0, "R6", int'(iv), 0);

    // R4/R5: issue of 11 while 12 dispatches
    step(1, 10, 3, 0, 0, 1, 0, 0, 0);
    step(1, 11, 0, 1, 0, 1, 0, 0, 0);
    step(1, 12, 3, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 3, 0);
    #1 chk(iv && ipl == 8'd10, "R4", int'(ipl), 10);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    #1 chk(iv && ipl == 8'd12, "R5", int'(ipl), 12);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R7: broadcast during dispatch
    step(1, 20, 7, 0, 7, 0, 1, 7, 0);
    #1 chk(iv && ipl == 8'd20, "R7", int'(ipl), 20);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R8: full queue
    for (int j = 0; j < DEPTH; j++) step(1, 21 + j, 9, 0, 0, 1, 0, 0, 0);
    #1 chk(drdy == 1'b0, "R8", int'(drdy), 0);
    step(0, 0, 0, 0, 0, 0, 1, 9, 0);
    #1 chk(drdy == 1'b1, "R8", int'(drdy), 1);
    step(1, 30, 0, 1, 0, 1, 0, 0, 0);

    // R9: flush with a competing dispatch
    step(1, 40, 0, 1, 0, 1, 0, 0, 1);
    #1 chk(iv == 1'b0 && drdy == 1'b1, "R9", int'(iv), 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // sweep
    rs = 32'h1234_5679;
    for (int c = 0; c < 4000; c++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      step(rs[0] | rs[1], c & 8'hff, int'(rs[5:2]), rs[6] | rs[7],
           int'(rs[11:8]), rs[12] | rs[13], rs[14], int'(rs[18:15]),
           rs[24:19] == 6'd0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule